// File: doc/BRIEF.md
# Memory Bit Invert Read-Modify-Write

This block flips one bit of a byte held in memory as a single indivisible operation. It also reports the bit's value before the flip through the processor's zero flag. The execute stage presents a two-halfword instruction together with the values of its two source registers, and raises `start` for one cycle. The block decodes which of its two operand forms the instruction uses. It reads the byte, writes the byte back with only the selected bit inverted, and in the same cycle posts the zero-flag update.

The immediate form carries the bit number in the opcode and forms the address from a base register plus a signed 16-bit displacement. The register form takes the bit number from the low bits of a second register and uses the base register alone as the address. The whole sequence takes three cycles: accept, read, write. No new instruction is taken while a sequence is in flight.

Top module: `bitinv_rmw`

## Requirements
- R1: Immediate form is recognised when `instr_hi[15:14]` = 2'b01 and `instr_hi[10:5]` = 6'b111110. The bit number is `instr_hi[13:11]`.
- R2: In the immediate form, `mem_addr` equals `reg1_val` plus `instr_lo` sign-extended to 32 bits.
- R3: Register form is recognised when `instr_hi[10:5]` = 6'b111111 and `instr_lo` = 16'h00E2. In this form, `mem_addr` equals `reg1_val` with no displacement.
- R4: In the register form, the bit number is `reg2_val[2:0]`. Bits 31:3 of `reg2_val` have no effect.
- R5: In the write cycle, `flag_we` is 1 and `flag_z` equals the inverse of the selected bit of the byte returned on `mem_rdata`.
- R6: `mem_wdata` equals `mem_rdata` with only the selected bit inverted, so the written bit equals `flag_z`. The write is issued on every operation. Applying the same operation twice restores the original byte.
- R7: Suppose `start` is accepted at the clock edge ending cycle k. Then `mem_rd` is 1 in cycle k+1. `mem_wr`, `done` and `flag_we` are 1 in cycle k+2 with the same `mem_addr`. Read data is expected one cycle after `mem_rd`.
- R8: `start` is ignored while `busy` is 1, including the write cycle. It is also ignored when the halfwords match neither form: no memory access follows.
- R9: After reset, `busy`, `mem_rd`, `mem_wr`, `flag_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to execute the presented instruction |
| instr_hi | input | 16 | First instruction halfword |
| instr_lo | input | 16 | Second instruction halfword |
| reg1_val | input | 32 | Base register value |
| reg2_val | input | 32 | Bit-number register value (register form) |
| busy | output | 1 | Sequence in flight |
| mem_rd | output | 1 | Byte read strobe |
| mem_wr | output | 1 | Byte write strobe |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after `mem_rd` |
| flag_we | output | 1 | Zero-flag update strobe |
| flag_z | output | 1 | New zero-flag value |
| done | output | 1 | Final cycle of the sequence |

## Verification
The assertions assume a memory that returns the addressed byte exactly one cycle after `mem_rd` and holds it through the write cycle. The bench memory model does exactly that, so checks tying `flag_z` and `mem_wdata` to `mem_rdata` are meaningful. The checks also assume that a byte is written only by this block. The bench memory changes only on `mem_wr`, so back-to-back operations on one byte see the byte the block last wrote. Stimulus sweeps every bit number in both forms and both displacement signs. It also drives garbage in the upper bits of the bit-number register, held requests while busy, and near-miss encodings.

// File: rtl/bitinv_pkg.sv
package bitinv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bitinv_state_e;

    localparam int HW_W    = 16;
    localparam int BYTE_W  = 8;
    localparam int BIT_W   = $clog2(BYTE_W);

    localparam logic [1:0]      IMM_TOP = 2'b01;
    localparam logic [5:0]      IMM_SUB = 6'b111110;
    localparam logic [5:0]      REG_SUB = 6'b111111;
    localparam logic [HW_W-1:0] REG_EXT = 16'h00E2;

endpackage

// File: rtl/bitinv_decode.sv
module bitinv_decode
    import bitinv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [HW_W-1:0]  hw_first,
    input  logic [HW_W-1:0]  hw_second,
    input  logic [XLEN-1:0]  idx_reg,
    output logic             form_imm,
    output logic             form_reg,
    output logic [BIT_W-1:0] bit_sel
);
    logic unused_fields;

    always_comb begin
        form_imm = (hw_first[15:14] == IMM_TOP) && (hw_first[10:5] == IMM_SUB);
        form_reg = (hw_first[10:5] == REG_SUB) && (hw_second == REG_EXT);
        bit_sel  = form_imm ? hw_first[13:11] : idx_reg[BIT_W-1:0];
    end

    // register numbers and upper index bits are not used by this block
    assign unused_fields = ^{hw_first[4:0], idx_reg[XLEN-1:BIT_W]};

endmodule

// File: rtl/bitinv_agen.sv
module bitinv_agen #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 16
) (
    input  logic [XLEN-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic              use_disp,
    output logic [XLEN-1:0]   addr
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        addr     = use_disp ? (base + disp_ext) : base;
    end

endmodule

// File: rtl/bitinv_modify.sv
module bitinv_modify
    import bitinv_pkg::*;
(
    input  logic [BYTE_W-1:0] old_byte,
    input  logic [BIT_W-1:0]  bit_sel,
    output logic [BYTE_W-1:0] new_byte,
    output logic              z_new
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign new_byte[i] = (bit_sel == BIT_W'(i)) ? ~old_byte[i] : old_byte[i];
    end

    assign z_new = ~old_byte[bit_sel];

endmodule

// File: rtl/bitinv_rmw.sv
module bitinv_rmw
    import bitinv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr_hi,
    input  logic [15:0]       instr_lo,
    input  logic [XLEN-1:0]   reg1_val,
    input  logic [XLEN-1:0]   reg2_val,
    output logic              busy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [XLEN-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              flag_we,
    output logic              flag_z,
    output logic              done
);
    typedef struct packed {
        bitinv_state_e    st;
        logic [XLEN-1:0]  addr;
        logic [BIT_W-1:0] bitn;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             is_imm, is_reg, legal;
    logic [BIT_W-1:0] dec_bit;
    logic [XLEN-1:0]  agen_addr;
    logic [BYTE_W-1:0] mod_byte;
    logic             mod_z;

    bitinv_decode #(.XLEN(XLEN)) u_dec (
        .hw_first (instr_hi),
        .hw_second(instr_lo),
        .idx_reg  (reg2_val),
        .form_imm (is_imm),
        .form_reg (is_reg),
        .bit_sel  (dec_bit)
    );

    bitinv_agen #(.XLEN(XLEN), .DISP_W(HW_W)) u_agen (
        .base    (reg1_val),
        .disp    (instr_lo),
        .use_disp(is_imm),
        .addr    (agen_addr)
    );

    bitinv_modify u_mod (
        .old_byte(mem_rdata),
        .bit_sel (ctl_q.bitn),
        .new_byte(mod_byte),
        .z_new   (mod_z)
    );

    assign legal = is_imm || is_reg;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start && legal) begin
                    ctl_d.st   = ST_READ;
                    ctl_d.addr = agen_addr;
                    ctl_d.bitn = dec_bit;
                end
            end
            ST_READ:  ctl_d.st = ST_WRITE;
            ST_WRITE: ctl_d.st = ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, bitn: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st != ST_IDLE);
    assign mem_rd    = (ctl_q.st == ST_READ);
    assign mem_wr    = (ctl_q.st == ST_WRITE);
    assign mem_addr  = ctl_q.addr;
    assign mem_wdata = mod_byte;
    assign flag_we   = mem_wr;
    assign flag_z    = mod_z;
    assign done      = mem_wr;

    AST_ACCEPT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start && legal && !busy) |=> mem_rd);                          // R1
    AST_IGNORE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && legal)) |=> !mem_rd);                      // R8
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr && $stable(mem_addr)));                      // R7
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_rd);                                            // R8
    AST_Z_IS_NEW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_z == (|(mem_wdata & ~mem_rdata))));          // R5
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_wdata ^ mem_rdata) == 1));           // R6
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));                                           // R7

endmodule

// File: tb/bitinv_rmw_test.sv
module bitinv_rmw_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr_hi = '0;
    logic [15:0] instr_lo = '0;
    logic [31:0] reg1_val = '0;
    logic [31:0] reg2_val = '0;
    logic        busy, mem_rd, mem_wr, flag_we, flag_z, done;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  memv [16];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitinv_rmw uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .instr_hi(instr_hi), .instr_lo(instr_lo),
        .reg1_val(reg1_val), .reg2_val(reg2_val),
        .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .flag_we(flag_we), .flag_z(flag_z), .done(done)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= memv[mem_addr[3:0]];
        if (mem_wr) memv[mem_addr[3:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // one full operation; expected address and bit given by caller
    task automatic run_op(input logic [15:0] h0, input logic [15:0] h1,
                          input logic [31:0] r1, input logic [31:0] r2,
                          input logic [31:0] exp_addr, input int exp_bit,
                          input string req);
        logic [7:0] old_b;
        logic [7:0] exp_w;
        @(negedge clk);
        instr_hi = h0; instr_lo = h1; reg1_val = r1; reg2_val = r2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(mem_rd === 1'b1 && busy === 1'b1, {req, " R7 read cycle"}, {30'd0, busy, mem_rd}, 32'h3);
        check(mem_addr === exp_addr, {req, " address"}, mem_addr, exp_addr);
        old_b = memv[exp_addr[3:0]];
        exp_w = old_b ^ (8'h01 << exp_bit);
        @(negedge clk);
        check(mem_wr === 1'b1 && done === 1'b1 && flag_we === 1'b1 && mem_rd === 1'b0,
              {req, " R7 write cycle"}, {28'd0, mem_rd, flag_we, done, mem_wr}, 32'h7);
        check(mem_addr === exp_addr, {req, " R7 address held"}, mem_addr, exp_addr);
        check(flag_z === ~old_b[exp_bit], {req, " R5 zero flag"}, {31'd0, flag_z}, {31'd0, ~old_b[exp_bit]});
        check(mem_wdata === exp_w, {req, " R6 written byte"}, {24'd0, mem_wdata}, {24'd0, exp_w});
        @(negedge clk);
        check(busy === 1'b0 && mem_wr === 1'b0, {req, " R7 back to idle"}, {30'd0, busy, mem_wr}, 32'h0);
    endtask

    function automatic logic [15:0] imm_hw(input int b);
        return {2'b01, 3'(b), 6'b111110, 5'd4};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        report();
    end

    initial begin
        for (int i = 0; i < 16; i++) memv[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0 && flag_we === 1'b0 && done === 1'b0,
              "R9 reset state", {27'd0, busy, mem_rd, mem_wr, flag_we, done}, 32'h0);
        rst_n = 1'b1;

        // R1 R2: immediate form, every bit, both displacement signs
        for (int b = 0; b < 8; b++) begin
            logic [31:0] base;
            base = 32'h1000_0040 + 32'(b);
            run_op(imm_hw(b), 16'h0003, base, 32'hFFFF_FFFF, base + 32'd3, b, "R1 R2 imm +disp");
            run_op(imm_hw(b), 16'hFFFE, base, 32'h0, base - 32'd2, b, "R1 R2 imm -disp");
        end

        // R3 R4: register form, upper index bits filled with garbage
        for (int b = 0; b < 8; b++) begin
            logic [31:0] base;
            base = 32'h2000_0000 + 32'(b * 3);
            run_op(16'h17E3, 16'h00E2, base, 32'h5A5A_5A50 | 32'(b), base, b, "R3 R4 reg form");
            run_op(16'h17E3, 16'h00E2, base, 32'hFFFF_FFF8 | 32'(b), base, b, "R3 R4 reg form hi ones");
        end

        // R6: same operation twice restores the byte
        begin
            logic [7:0] orig;
            orig = memv[4'h9];
            run_op(imm_hw(5), 16'h0000, 32'h0000_0009, 32'h0, 32'h9, 5, "R6 first");
            run_op(imm_hw(5), 16'h0000, 32'h0000_0009, 32'h0, 32'h9, 5, "R6 second");
            @(negedge clk);
            check(memv[4'h9] === orig, "R6 byte restored", {24'd0, memv[4'h9]}, {24'd0, orig});
        end

        // R8: encodings matching neither form are ignored
        begin
            logic [15:0] bad_hi [3];
            logic [15:0] bad_lo [3];
            bad_hi[0] = 16'h17E3; bad_lo[0] = 16'h00E3;
            bad_hi[1] = {2'b10, 3'd2, 6'b111110, 5'd4}; bad_lo[1] = 16'h0000;
            bad_hi[2] = {2'b01, 3'd2, 6'b111100, 5'd4}; bad_lo[2] = 16'h00E2;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                instr_hi = bad_hi[k]; instr_lo = bad_lo[k]; reg1_val = 32'h3; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(mem_rd === 1'b0 && busy === 1'b0, "R8 illegal ignored", {30'd0, busy, mem_rd}, 32'h0);
                @(negedge clk);
                check(mem_wr === 1'b0 && flag_we === 1'b0, "R8 no write", {30'd0, flag_we, mem_wr}, 32'h0);
            end
        end

        // R8: start held while busy is not taken
        @(negedge clk);
        instr_hi = imm_hw(1); instr_lo = 16'h0000; reg1_val = 32'h2; start = 1'b1;
        @(negedge clk);
        check(mem_rd === 1'b1 && mem_addr === 32'h2, "R8 first accepted", mem_addr, 32'h2);
        instr_hi = 16'h17E3; instr_lo = 16'h00E2; reg1_val = 32'h7; reg2_val = 32'h3;
        @(negedge clk);
        check(mem_wr === 1'b1 && mem_addr === 32'h2, "R8 busy write kept", mem_addr, 32'h2);
        @(negedge clk);
        start = 1'b0;
        check(mem_rd === 1'b0 && busy === 1'b0, "R8 held start ignored", {30'd0, busy, mem_rd}, 32'h0);
        repeat (2) @(negedge clk);
        check(mem_rd === 1'b0 && mem_wr === 1'b0, "R8 stays idle", {30'd0, mem_rd, mem_wr}, 32'h0);

        report();
    end

endmodule